// File: doc/BRIEF.md
# Next Program Counter Selector

This unit decides where a 32-bit RISC core fetches its next instruction. In the same cycle it receives the current fetch address and the control-flow class of the instruction that sits there. That class is one of six: fall-through, branch-if-equal, branch-if-different, absolute jump, call, or jump through a register. The unit returns the address to fetch next, along with the write request that stores a return address.

Branches are PC-relative. They compare two register operands and, when taken, add a sign-extended, word-scaled displacement to the address of the following instruction. Absolute jumps take their upper four bits from the incremented PC and fill the rest from a 26-bit word index. A register-indirect jump passes a register value straight through. A call writes the incremented PC to the fixed return register. The unit is purely combinational, and the pipeline that surrounds it registers its output.

Top module: `nextpc_unit`

## Requirements
- R1: With `flow_sel` = 0 (fall-through), `pc_next` equals `pc_cur` + 4. The class codes are 0 fall-through, 1 branch-if-equal, 2 branch-if-different, 3 jump, 4 call, 5 register jump.
- R2: With class 1 and `cmp_a` == `cmp_b`, `pc_next` equals `pc_cur` + 4 + 4×offset. An offset of 25 adds 100.
- R3: With class 1 and unequal operands, `pc_next` equals `pc_cur` + 4.
- R4: With class 2, the branch is taken (R2 target) when the operands differ, and `pc_next` equals `pc_cur` + 4 when they are equal.
- R5: The 16-bit offset is sign-extended before it is scaled. 0xFFFF moves the target back by 4, and 0x8000 moves it back by 131072.
- R6: With class 3, `pc_next` is bits 31:28 of `pc_cur` + 4, followed by `jmp_field`, followed by two zero bits. A field of 2500 in region 0 gives 10000.
- R7: With class 4, `pc_next` follows R6, `link_we` is 1 and `link_val` equals `pc_cur` + 4.
- R8: With class 5, `pc_next` equals `reg_tgt` exactly, including its two low bits.
- R9: `link_we` is 0 for every class other than 4, and `link_idx` is always 31.
- R10: Class codes 6 and 7 act as fall-through, with `pc_next` = `pc_cur` + 4 and `link_we` = 0.
- R11: Address arithmetic wraps modulo 2^32, so fall-through from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the current instruction |
| br_ofs | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word index of an absolute jump |
| reg_tgt | input | 32 | Register value for register jumps |
| cmp_a | input | 32 | First branch comparison operand |
| cmp_b | input | 32 | Second branch comparison operand |
| flow_sel | input | 3 | Control-flow class code |
| pc_next | output | 32 | Address to fetch next |
| link_we | output | 1 | Write request for the return register |
| link_idx | output | 5 | Index of the return register |
| link_val | output | 32 | Return address to write |

## Verification
Each branch class is driven with equal operands and again with operands that differ in only one bit. This tells a true equality test apart from a partial compare, and it separates the equal polarity from the not-equal polarity. Offsets of 25, -1 and the most negative value separate correct sign extension and scaling from zero extension or a missing shift. Jumps are tried from a low region and from a high region with an all-ones field, which shows whether the upper bits come from the incremented PC. Random traffic over all eight codes, including the two unused ones, checks that only the call class requests a link write.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter int XLEN   = 32,
  parameter int OFS_W  = 16,
  parameter int FLD_W  = 26,
  parameter int RIDX_W = 5,
  parameter int RA_NUM = 31
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic [FLD_W-1:0]  jmp_field,
  input  logic [XLEN-1:0]   reg_tgt,
  input  logic [XLEN-1:0]   cmp_a,
  input  logic [XLEN-1:0]   cmp_b,
  input  logic [2:0]        flow_sel,
  output logic [XLEN-1:0]   pc_next,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);
  localparam int HI_W = XLEN - FLD_W - 2;
  localparam logic [2:0] F_SEQ = 3'd0, F_BEQ = 3'd1, F_BNE = 3'd2,
                         F_JMP = 3'd3, F_JAL = 3'd4, F_JR  = 3'd5;

  logic [XLEN-1:0] pc_seq, br_disp, br_tgt, jmp_tgt;
  logic            same, take;

  assign pc_seq  = pc_cur + XLEN'(4);
  assign br_disp = {{(XLEN-OFS_W-2){br_ofs[OFS_W-1]}}, br_ofs, 2'b00};
  assign br_tgt  = pc_seq + br_disp;
  assign jmp_tgt = {pc_seq[XLEN-1 -: HI_W], jmp_field, 2'b00};
  assign same    = (cmp_a == cmp_b);
  assign take    = (flow_sel == F_BEQ && same) || (flow_sel == F_BNE && !same);

  always_comb begin
    unique case (flow_sel)
      F_BEQ, F_BNE: pc_next = take ? br_tgt : pc_seq;
      F_JMP, F_JAL: pc_next = jmp_tgt;
      F_JR:         pc_next = reg_tgt;
      default:      pc_next = pc_seq;
    endcase
  end

  assign link_we  = (flow_sel == F_JAL);
  assign link_idx = RIDX_W'(RA_NUM);
  assign link_val = pc_seq;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int XLEN   = 32,
  parameter int OFS_W  = 16,
  parameter int FLD_W  = 26,
  parameter int RIDX_W = 5
) (
  input logic [XLEN-1:0]   pc_cur,
  input logic [OFS_W-1:0]  br_ofs,
  input logic [FLD_W-1:0]  jmp_field,
  input logic [XLEN-1:0]   reg_tgt,
  input logic [XLEN-1:0]   cmp_a,
  input logic [XLEN-1:0]   cmp_b,
  input logic [2:0]        flow_sel,
  input logic [XLEN-1:0]   pc_next,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_idx,
  input logic [XLEN-1:0]   link_val
);
  logic [XLEN-1:0] inc;
  assign inc = pc_cur + XLEN'(4);

  always_comb begin
    if (flow_sel == 3'd1 && cmp_a != cmp_b) AST_BEQ_FALL: assert (pc_next == inc);   // R3
    if (flow_sel == 3'd2 && cmp_a == cmp_b) AST_BNE_FALL: assert (pc_next == inc);   // R4
    if (flow_sel == 3'd3 || flow_sel == 3'd4)
      AST_JUMP_REGION: assert (pc_next[XLEN-1 -: 4] == inc[XLEN-1 -: 4] && pc_next[1:0] == 2'b00); // R6
    if (link_we) AST_LINK_VAL: assert (link_val == inc && pc_next[1:0] == 2'b00);    // R7
    if (flow_sel == 3'd5) AST_JR_PASS: assert (pc_next == reg_tgt);                  // R8
    if (link_we) AST_LINK_GATE: assert (flow_sel == 3'd4);                           // R9
    if (flow_sel[2:1] == 2'b11) AST_SPARE_SEQ: assert (pc_next == inc && !link_we);  // R10
  end
endmodule

bind nextpc_unit nextpc_unit_chk #(
  .XLEN(XLEN), .OFS_W(OFS_W), .FLD_W(FLD_W), .RIDX_W(RIDX_W)
) u_chk (
  .pc_cur(pc_cur), .br_ofs(br_ofs), .jmp_field(jmp_field), .reg_tgt(reg_tgt),
  .cmp_a(cmp_a), .cmp_b(cmp_b), .flow_sel(flow_sel), .pc_next(pc_next),
  .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pc_cur = '0, reg_tgt = '0, cmp_a = '0, cmp_b = '0;
  logic [15:0] br_ofs = '0;
  logic [25:0] jmp_field = '0;
  logic [2:0]  flow_sel = '0;
  logic [31:0] pc_next, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  nextpc_unit u_dut (
    .pc_cur(pc_cur), .br_ofs(br_ofs), .jmp_field(jmp_field), .reg_tgt(reg_tgt),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .flow_sel(flow_sel), .pc_next(pc_next),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  function automatic longint ref_pc(longint pc, longint ofs, longint fld,
                                    longint rv, longint a, longint b, int sel);
    longint p4, sofs, res;
    p4   = (pc + 4) % 64'h1_0000_0000;
    sofs = (ofs >= 32768) ? ofs - 65536 : ofs;
    case (sel)
      1: res = (a == b) ? p4 + sofs * 4 : p4;
      2: res = (a != b) ? p4 + sofs * 4 : p4;
      3, 4: res = (p4 / 268435456) * 268435456 + fld * 4;
      5: res = rv;
      default: res = p4;
    endcase
    res = res % 64'h1_0000_0000;
    if (res < 0) res = res + 64'h1_0000_0000;
    return res;
  endfunction

  task automatic step(input int sel, input logic [31:0] pc, input logic [15:0] ofs,
                      input logic [25:0] fld, input logic [31:0] rv,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    longint e_pc, e_lv;
    bit e_we;
    @(posedge clk);
    flow_sel = sel[2:0]; pc_cur = pc; br_ofs = ofs; jmp_field = fld;
    reg_tgt = rv; cmp_a = a; cmp_b = b;
    @(negedge clk);
    e_pc = ref_pc(pc, ofs, fld, rv, a, b, sel);
    e_we = (sel == 4);
    e_lv = (longint'(pc) + 4) % 64'h1_0000_0000;
    n_cmp++;
    if (longint'(pc_next) != e_pc || link_we != e_we || link_idx != 5'd31 ||
        (e_we && longint'(link_val) != e_lv)) begin
      n_bad++;
      $display("FAIL %s: sel=%0d got pc=%h we=%b idx=%0d lv=%h exp pc=%h we=%b idx=31 lv=%h",
               tag, sel, pc_next, link_we, link_idx, link_val, e_pc[31:0], e_we, e_lv[31:0]);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    step(0, 32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, "R1 reset-state");
    step(0, 32'h0040_0000, 16'h0, 26'h0, 32'h0, 32'h1, 32'h1, "R1");
    step(0, 32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, "R11");
    step(1, 32'h0000_1000, 16'd25, 26'h0, 32'h0, 32'h55, 32'h55, "R2");
    step(1, 32'h0000_1000, 16'd25, 26'h0, 32'h0, 32'h55, 32'h8000_0055, "R3");
    step(1, 32'h0000_1000, 16'd25, 26'h0, 32'h0, 32'h1, 32'h0, "R3");
    step(2, 32'h0000_2000, 16'd25, 26'h0, 32'h0, 32'h7, 32'h6, "R4 taken");
    step(2, 32'h0000_2000, 16'd25, 26'h0, 32'h0, 32'h7, 32'h7, "R4 fall");
    step(1, 32'h0000_3000, 16'hFFFF, 26'h0, 32'h0, 32'h9, 32'h9, "R5");
    step(2, 32'h0010_0000, 16'h8000, 26'h0, 32'h0, 32'h1, 32'h2, "R5");
    step(3, 32'h0000_0000, 16'h0, 26'd2500, 32'h0, 32'h0, 32'h0, "R6");
    step(3, 32'h9000_0010, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0, "R6");
    step(3, 32'h2FFF_FFFC, 16'h0, 26'h10, 32'h0, 32'h0, 32'h0, "R6 region");
    step(4, 32'h0040_0100, 16'h0, 26'd2500, 32'h0, 32'h0, 32'h0, "R7");
    step(5, 32'h0040_0200, 16'h0, 26'h0, 32'h1234_5677, 32'h0, 32'h0, "R8");
    step(6, 32'h0000_0400, 16'h7, 26'h5, 32'hABCD_0000, 32'h3, 32'h3, "R10");
    step(7, 32'h0000_0800, 16'h7, 26'h5, 32'hABCD_0000, 32'h3, 32'h4, "R10");
    step(5, 32'h0000_0800, 16'h7, 26'h5, 32'h0, 32'h3, 32'h3, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (i % 2 == 0) ? ra : ra ^ (32'h1 << (i % 32));
      step(i % 8, $urandom, 16'($urandom), 26'($urandom), $urandom, ra, rb, "R9 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule